// File: doc/BRIEF.md
# Parallel Converter Bus Master

This block is the host side of a parallel-bus successive-approximation converter. It takes conversion requests on a valid/ready port. Each request carries a channel address, the input referencing, the polarity, the sampling style and a power code. The block turns each request into control writes on a shared 12-bit data bus, using chip select, a write strobe and a read strobe. It then watches the converter's active-low done line and reads the result back. The result leaves on an output stream, tagged with the channel that produced it.

Two sampling styles are offered. With internal sampling, one write starts the acquisition and the conversion together. With host-timed sampling, a first write opens the sampling window and a second write closes it and starts the conversion. A pipelined mode can be selected. In that mode, when a new request is already waiting at the moment the done line falls, the new control write is issued before the previous result is read back, so the next conversion overlaps the read. Every strobe width, the power-up wait and the done watchdog are counted in system clocks.

The data bus is split into a driven value, an output enable and a returned value. The pad-level three-state buffer sits outside this block.

Top module: `adc_bus_master`

## Requirements
- R1: The control byte sits on `bus_d_out[7:0]`, with the upper bus bits at zero. From bit 7 down to bit 0 it holds: power code (bits 7:6, where 2'b10 and 2'b11 convert and 2'b00 and 2'b01 power down), the sampling bit (bit 5, 1 opens a host-timed sampling window), the reference bit (bit 4, 1 selects single-ended), the polarity bit (bit 3, 1 selects unipolar) and the channel address (bits 2:0).
- R2: A converting request with internal sampling makes exactly one write, with bit 5 at 0.
- R3: A converting request with host-timed sampling makes two writes. The first has bit 5 at 1 and the second has bit 5 at 0. All other bits are identical in both writes. At least ACQ_GAP cycles pass between the first write's rising edge and the second write's falling edge.
- R4: The write strobe stays low for exactly WR_CYC cycles, and only while chip select is low. The data does not change during the strobe and is still driven, with chip select low, in the cycle after the strobe rises.
- R5: The data output enable is on only during write cycles. It is never on while the read strobe is low, and the two strobes are never low together.
- R6: After the done line falls, chip select and the read strobe go low for RD_CYC cycles. The bus value in the last low cycle comes out as a one-cycle `res_valid` pulse, with `res_chan` equal to the channel of the request that produced it.
- R7: In pipelined mode, a request accepted while a result is pending has its control write issued before that result is read. The result is still tagged with the earlier request's channel, and results leave in request order.
- R8: A request with a power-down code makes a single write, with bit 5 at 0, and no read and no result.
- R9: After reset, `req_ready` stays low for PWRUP_CYC cycles before the first request can be accepted.
- R10: If the done line does not fall within TIMEOUT_CYC cycles of the conversion start, `timeout_err` pulses for one cycle, no result is produced and the block accepts requests again.
- R11: During reset, chip select and both strobes are high, the data output enable is off, and `res_valid`, `timeout_err` and `req_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_mode | input | 1 | 1 lets the next control write come before the pending read |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this cycle when valid |
| req_chan | input | 3 | Channel address |
| req_single | input | 1 | 1 single-ended, 0 pseudo-differential |
| req_unipolar | input | 1 | 1 unipolar, 0 bipolar |
| req_ext_acq | input | 1 | 1 host-timed sampling with two writes |
| req_pwr | input | 2 | Power and clock code |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DW | Converted value |
| res_chan | output | 3 | Channel that produced the value |
| timeout_err | output | 1 | One-cycle pulse on a missing done |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_d_oe | output | 1 | Data driver enable |
| bus_d_out | output | DW | Data driven during writes |
| bus_d_in | input | DW | Data returned by the converter |
| bus_done_n | input | 1 | Conversion done, active low |

## Verification
The assertions assume that the done line changes only between rising clock edges and is synchronous to `clk`. They also assume that the converter releases done on a read or write and lowers it only after a conversion it was given. The bench's converter model updates all of its outputs on the falling clock edge. It returns junk in the first read cycle and the real value from the second, and it holds its last result until a later conversion completes. Requests are presented after the falling edge and removed right after acceptance, so the request fields stay stable while they are valid.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

  typedef struct packed {
    logic [1:0] pwr;
    logic       ext_acq;
    logic       single;
    logic       unipolar;
    logic [2:0] chan;
  } adc_req_t;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} bus_ph_t;

  typedef enum logic [2:0] {
    S_PWRUP, S_IDLE, S_WRA, S_GAP, S_WRC, S_CONV, S_RD
  } mst_st_t;

  // control byte, bit 7 down to bit 0
  function automatic logic [7:0] ctrl_byte(adc_req_t r, logic acq_bit);
    return {r.pwr, acq_bit, r.single, r.unipolar, r.chan};
  endfunction

  // power codes with bit 1 set keep the converter running
  function automatic logic pwr_converts(logic [1:0] p);
    return p[1];
  endfunction

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/adc_cycle_timer.sv
module adc_cycle_timer #(
  parameter int CW      = 8,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= CW'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/adc_strobe_seq.sv
module adc_strobe_seq
  import adc_bus_pkg::*;
#(
  parameter int DW        = 12,
  parameter int SETUP_CYC = 1,
  parameter int WR_CYC    = 4,
  parameter int RD_CYC    = 3,
  parameter int HOLD_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_read,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          op_done,
  output logic [DW-1:0] rdata,
  output logic          cs_n,
  output logic          wr_n,
  output logic          rd_n,
  output logic          d_oe,
  output logic [DW-1:0] d_out,
  input  logic [DW-1:0] d_in
);
  localparam int MAXC = max4(SETUP_CYC, WR_CYC, RD_CYC, HOLD_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  bus_ph_t       ph;
  logic [CW-1:0] cnt;
  logic          rd_op;
  logic [DW-1:0] wbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      rd_op <= 1'b0;
      wbuf  <= '0;
      rdata <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph    <= PH_SETUP;
          cnt   <= CW'(SETUP_CYC - 1);
          rd_op <= is_read;
          wbuf  <= wdata;
        end
        PH_SETUP: if (cnt == '0) begin
          ph  <= PH_STROBE;
          cnt <= rd_op ? CW'(RD_CYC - 1) : CW'(WR_CYC - 1);
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cnt == '0) begin
          ph  <= PH_HOLD;
          cnt <= CW'(HOLD_CYC - 1);
          if (rd_op) rdata <= d_in;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) ph <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign busy    = (ph != PH_IDLE);
  assign op_done = (ph == PH_HOLD) && (cnt == '0);
  assign cs_n    = (ph == PH_IDLE);
  assign wr_n    = !((ph == PH_STROBE) && !rd_op);
  assign rd_n    = !((ph == PH_STROBE) && rd_op);
  assign d_oe    = (ph != PH_IDLE) && !rd_op;
  assign d_out   = wbuf;

  // checker: length of the current write-low run
  logic [CW:0] wr_len;
  always_ff @(posedge clk) begin
    if (!rst_n)     wr_len <= '0;
    else if (!wr_n) wr_len <= wr_len + 1'b1;
    else            wr_len <= '0;
  end

  a_r5_no_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !d_oe);
  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> $stable(d_out));
  a_r4_hold_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (d_oe && !cs_n));
  a_r4_wr_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (wr_len == (CW+1)'(WR_CYC)));
endmodule

// File: rtl/adc_bus_master.sv
module adc_bus_master
  import adc_bus_pkg::*;
#(
  parameter int DW          = 12,
  parameter int SETUP_CYC   = 1,
  parameter int WR_CYC      = 4,
  parameter int RD_CYC      = 3,
  parameter int HOLD_CYC    = 1,
  parameter int ACQ_GAP     = 4,
  parameter int PWRUP_CYC   = 1000,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_chan,
  input  logic          req_single,
  input  logic          req_unipolar,
  input  logic          req_ext_acq,
  input  logic [1:0]    req_pwr,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic [2:0]    res_chan,
  output logic          timeout_err,
  output logic          bus_cs_n,
  output logic          bus_wr_n,
  output logic          bus_rd_n,
  output logic          bus_d_oe,
  output logic [DW-1:0] bus_d_out,
  input  logic [DW-1:0] bus_d_in,
  input  logic          bus_done_n
);
  localparam int PW = $clog2(PWRUP_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int GW = $clog2(ACQ_GAP + 1);

  mst_st_t       st;
  adc_req_t      cur, req_in;
  logic [2:0]    prev_chan;
  logic          pend_rd, issued;
  logic [GW-1:0] gap_cnt;

  logic          seq_start, seq_busy, seq_done;
  logic [DW-1:0] seq_rdata, seq_wdata;
  logic          pwr_expired, wd_expired, wd_load;
  logic          op_state, conv_timeout;

  assign req_in = '{pwr: req_pwr, ext_acq: req_ext_acq, single: req_single,
                    unipolar: req_unipolar, chan: req_chan};

  function automatic mst_st_t first_state(adc_req_t r);
    return (r.ext_acq && pwr_converts(r.pwr)) ? S_WRA : S_WRC;
  endfunction

  assign req_ready = (st == S_IDLE) ||
                     ((st == S_CONV) && pipe_mode && !bus_done_n);

  assign op_state     = (st == S_WRA) || (st == S_WRC) || (st == S_RD);
  assign seq_start    = op_state && !seq_busy && !issued;
  assign seq_wdata    = DW'(ctrl_byte(cur, st == S_WRA));
  assign conv_timeout = (st == S_CONV) && wd_expired && bus_done_n;
  assign wd_load      = seq_done && pwr_converts(cur.pwr) &&
                        (((st == S_WRC) && !pend_rd) || ((st == S_RD) && pend_rd));

  adc_strobe_seq #(
    .DW(DW), .SETUP_CYC(SETUP_CYC), .WR_CYC(WR_CYC),
    .RD_CYC(RD_CYC), .HOLD_CYC(HOLD_CYC)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .is_read(st == S_RD),
    .wdata(seq_wdata), .busy(seq_busy), .op_done(seq_done), .rdata(seq_rdata),
    .cs_n(bus_cs_n), .wr_n(bus_wr_n), .rd_n(bus_rd_n), .d_oe(bus_d_oe),
    .d_out(bus_d_out), .d_in(bus_d_in)
  );

  adc_cycle_timer #(.CW(PW), .RST_VAL(PWRUP_CYC)) i_pwrup (
    .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0), .expired(pwr_expired)
  );

  adc_cycle_timer #(.CW(TW), .RST_VAL(0)) i_wdog (
    .clk(clk), .rst_n(rst_n), .load(wd_load), .load_val(TW'(TIMEOUT_CYC)),
    .expired(wd_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) issued <= 1'b0;
    else if (seq_done) issued <= 1'b0;
    else if (seq_start) issued <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_PWRUP;
      cur         <= '0;
      prev_chan   <= '0;
      pend_rd     <= 1'b0;
      gap_cnt     <= '0;
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_chan    <= '0;
      timeout_err <= 1'b0;
    end else begin
      res_valid   <= 1'b0;
      timeout_err <= 1'b0;
      case (st)
        S_PWRUP: if (pwr_expired) st <= S_IDLE;
        S_IDLE: if (req_valid) begin
          cur <= req_in;
          st  <= first_state(req_in);
        end
        S_WRA: if (seq_done) begin
          st      <= S_GAP;
          gap_cnt <= GW'(ACQ_GAP - 1);
        end
        S_GAP: if (gap_cnt == '0) st <= S_WRC;
               else gap_cnt <= gap_cnt - 1'b1;
        S_WRC: if (seq_done) begin
          if (pend_rd)                    st <= S_RD;
          else if (pwr_converts(cur.pwr)) st <= S_CONV;
          else                            st <= S_IDLE;
        end
        S_CONV: begin
          if (conv_timeout) begin
            timeout_err <= 1'b1;
            st          <= S_IDLE;
          end else if (!bus_done_n) begin
            prev_chan <= cur.chan;
            if (pipe_mode && req_valid) begin
              pend_rd <= 1'b1;
              cur     <= req_in;
              st      <= first_state(req_in);
            end else st <= S_RD;
          end
        end
        S_RD: if (seq_done) begin
          res_valid <= 1'b1;
          res_data  <= seq_rdata;
          res_chan  <= prev_chan;
          if (pend_rd) begin
            pend_rd <= 1'b0;
            st      <= pwr_converts(cur.pwr) ? S_CONV : S_IDLE;
          end else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // checker: remember the previous write for the two-write comparison
  logic       wr_n_q, last_acq1;
  logic [7:0] last_byte;
  logic       wr_rise;
  assign wr_rise = bus_wr_n && !wr_n_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_n_q    <= 1'b1;
      last_acq1 <= 1'b0;
      last_byte <= '0;
    end else begin
      wr_n_q <= bus_wr_n;
      if (wr_rise) begin
        last_acq1 <= bus_d_out[5];
        last_byte <= bus_d_out[7:0];
      end
    end
  end

  a_r3_second_write_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !bus_d_out[5] && last_acq1) |->
      (bus_d_out[7:6] == last_byte[7:6] && bus_d_out[4:0] == last_byte[4:0]));
  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_wr_n && !bus_rd_n));
  a_r4_strobes_need_cs: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |-> (bus_wr_n && bus_rd_n));
  a_r9_no_accept_before_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_expired |-> !req_ready);
  a_r10_timeout_needs_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (bus_done_n && !res_valid));
  a_r6_result_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(!bus_cs_n && bus_rd_n && !bus_d_oe));
endmodule

// File: tb/test_adc_bus_master.sv
`timescale 1ns/1ps
module test_adc_bus_master;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 12;
  localparam int WR_CYC     = 4;
  localparam int ACQ_GAP    = 4;
  localparam int PWRUP_CYC  = 1000;
  localparam int NVEC       = 8;

  // vector: {pwr[1:0], ext_acq, single, unipolar, chan[2:0]}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b10_0_1_1_000, 8'b11_0_0_1_011, 8'b10_1_1_0_101, 8'b11_1_0_0_010,
    8'b00_0_1_1_100, 8'b11_0_1_0_111, 8'b01_1_1_1_001, 8'b10_0_0_0_110
  };

  logic clk = 0, rst_n = 0, pipe_mode = 0, req_valid = 0;
  logic [2:0] req_chan = 0; logic req_single = 0, req_unipolar = 0, req_ext_acq = 0;
  logic [1:0] req_pwr = 0;
  logic req_ready, res_valid, timeout_err;
  logic [DW-1:0] res_data; logic [2:0] res_chan;
  logic bus_cs_n, bus_wr_n, bus_rd_n, bus_d_oe;
  logic [DW-1:0] bus_d_out, bus_d_in;
  logic bus_done_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_bus_master i_adc_bus_master (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_chan(req_chan), .req_single(req_single),
    .req_unipolar(req_unipolar), .req_ext_acq(req_ext_acq), .req_pwr(req_pwr),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
    .timeout_err(timeout_err), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
    .bus_rd_n(bus_rd_n), .bus_d_oe(bus_d_oe), .bus_d_out(bus_d_out),
    .bus_d_in(bus_d_in), .bus_done_n(bus_done_n)
  );

  int n_checks = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] conv_byte(logic [7:0] v);
    return {v[7:6], 1'b0, v[4:0]};
  endfunction
  function automatic logic [DW-1:0] model_value(logic [7:0] b);
    return {~b[3:0], b};
  endfunction

  // ---------------- converter model (falling edge) ----------------
  logic m_prev_wr, m_armed, m_mute;
  int m_cnt, m_rdcnt;
  logic [7:0] m_byte;
  logic [DW-1:0] m_res;
  initial m_mute = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      m_prev_wr <= 1; m_armed <= 0; m_cnt <= 0; m_rdcnt <= 0;
      m_byte <= 0; m_res <= 0; bus_done_n <= 1; bus_d_in <= 0;
    end else begin
      m_prev_wr <= bus_wr_n;
      if (!m_prev_wr && bus_wr_n && !bus_cs_n && bus_d_oe) begin
        bus_done_n <= 1;
        if (bus_d_out[5]) begin m_armed <= 1; m_cnt <= 0; end
        else if (bus_d_out[7]) begin
          m_cnt <= m_armed ? 13 : 16; m_armed <= 0; m_byte <= bus_d_out[7:0];
        end else begin m_armed <= 0; m_cnt <= 0; end
      end else if (m_cnt > 0) begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1 && !m_mute) begin
          bus_done_n <= 0; m_res <= model_value(m_byte);
        end
      end
      if (!bus_rd_n && !bus_cs_n) begin
        bus_done_n <= 1;
        bus_d_in <= (m_rdcnt >= 1) ? m_res : 12'hEEE;
        m_rdcnt <= m_rdcnt + 1;
      end else begin
        m_rdcnt <= 0; bus_d_in <= 0;
      end
    end
  end

  // ---------------- bus monitor ----------------
  int cyc = 0, wr_cnt = 0, rd_cnt = 0, res_n = 0, tmo_n = 0, wr_len = 0;
  logic [7:0] wlog [64];
  int rise_cyc [64], fall_cyc [64], res_wr_at [64];
  logic [DW-1:0] res_log [64];
  logic [2:0] chan_log [64];
  logic [DW-1:0] wfall_data;
  logic mon_wr = 1, mon_rd = 1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!bus_wr_n) wr_len++;
      if (mon_wr && !bus_wr_n) begin fall_cyc[wr_cnt] = cyc; wfall_data = bus_d_out; end
      if (!mon_wr && bus_wr_n) begin
        chk(wr_len == WR_CYC, "R4 write strobe width", wr_len, WR_CYC);
        chk(bus_d_out == wfall_data && bus_d_oe && !bus_cs_n, "R4 data held", bus_d_out, wfall_data);
        wlog[wr_cnt] = bus_d_out[7:0]; rise_cyc[wr_cnt] = cyc; wr_cnt++;
        wr_len = 0;
      end
      if (mon_rd && !bus_rd_n) rd_cnt++;
      if (bus_d_oe && !bus_rd_n) chk(0, "R5 driver on during read", 1, 0);
      if (!bus_wr_n && !bus_rd_n) chk(0, "R5 strobes overlap", 1, 0);
      if (res_valid) begin
        res_log[res_n] = res_data; chan_log[res_n] = res_chan; res_wr_at[res_n] = wr_cnt;
        res_n++;
      end
      if (timeout_err) tmo_n++;
    end
    mon_wr = bus_wr_n; mon_rd = bus_rd_n;
  end

  task automatic send_req(input logic [7:0] v);
    @(negedge clk); #1;
    req_valid = 1; req_pwr = v[7:6]; req_ext_acq = v[5];
    req_single = v[4]; req_unipolar = v[3]; req_chan = v[2:0];
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wait_res(input int target, input int limit);
    for (int k = 0; k < limit && res_n < target; k++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int w0, r0, d0;
    logic [7:0] v, b;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk(bus_cs_n && bus_wr_n && bus_rd_n, "R11 strobes high in reset", {bus_cs_n,bus_wr_n,bus_rd_n}, 3'b111);
    chk(!bus_d_oe && !res_valid && !timeout_err && !req_ready, "R11 outputs idle in reset",
        {bus_d_oe,res_valid,timeout_err,req_ready}, 0);
    rst_n = 1;
    // R9 power-up wait
    repeat (PWRUP_CYC - 1) @(negedge clk);
    chk(!req_ready, "R9 ready held during power-up", req_ready, 0);
    repeat (4) @(negedge clk);
    chk(req_ready, "R9 ready after power-up", req_ready, 1);

    // table walk, non-pipelined
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i]; b = conv_byte(v);
      w0 = wr_cnt; r0 = res_n; d0 = rd_cnt;
      send_req(v);
      if (v[7]) begin
        wait_res(r0 + 1, 300);
        chk(res_n == r0 + 1, "R6 result produced", res_n - r0, 1);
        chk(res_log[r0] == model_value(b), "R6 result value", res_log[r0], model_value(b));
        chk(chan_log[r0] == v[2:0], "R6 result channel", chan_log[r0], v[2:0]);
        if (v[5]) begin
          chk(res_wr_at[r0] == w0 + 2, "R3 two writes", res_wr_at[r0] - w0, 2);
          chk(wlog[w0] == {v[7:6], 1'b1, v[4:0]}, "R3 first write byte", wlog[w0], {v[7:6],1'b1,v[4:0]});
          chk(wlog[w0+1] == b, "R3 second write byte", wlog[w0+1], b);
          chk(fall_cyc[w0+1] - rise_cyc[w0] >= ACQ_GAP, "R3 sampling gap",
              fall_cyc[w0+1] - rise_cyc[w0], ACQ_GAP);
        end else begin
          chk(res_wr_at[r0] == w0 + 1, "R2 single write", res_wr_at[r0] - w0, 1);
          chk(wlog[w0] == b, "R1 R2 control byte", wlog[w0], b);
        end
      end else begin
        repeat (60) @(negedge clk);
        chk(wr_cnt == w0 + 1 && wlog[w0] == b, "R8 single power-down write", wlog[w0], b);
        chk(res_n == r0 && rd_cnt == d0, "R8 no read no result", res_n - r0 + rd_cnt - d0, 0);
      end
    end

    // R10 missing done
    m_mute = 1; r0 = res_n;
    send_req(8'b10_0_1_1_010);
    for (int k = 0; k < 300 && tmo_n == 0; k++) @(negedge clk);
    chk(tmo_n == 1, "R10 timeout pulse", tmo_n, 1);
    chk(res_n == r0, "R10 no result on timeout", res_n - r0, 0);
    @(negedge clk); #1;
    chk(req_ready, "R10 ready after timeout", req_ready, 1);
    m_mute = 0;

    // R7 pipelined ordering
    pipe_mode = 1; w0 = wr_cnt; r0 = res_n;
    fork
      begin
        send_req(8'b11_0_1_1_001);
        send_req(8'b10_0_0_1_100);
        send_req(8'b11_1_1_0_110);
      end
      wait_res(r0 + 3, 800);
    join
    chk(res_n == r0 + 3, "R7 three results", res_n - r0, 3);
    chk(chan_log[r0] == 3'd1 && chan_log[r0+1] == 3'd4 && chan_log[r0+2] == 3'd6,
        "R7 tags in request order", {chan_log[r0],chan_log[r0+1],chan_log[r0+2]}, 9'o146);
    chk(res_wr_at[r0] == w0 + 2, "R7 next write before first read", res_wr_at[r0] - w0, 2);
    chk(res_wr_at[r0+1] == w0 + 4, "R7 host-timed writes before second read", res_wr_at[r0+1] - w0, 4);
    chk(res_log[r0] == model_value(8'b11_0_1_1_001), "R7 first value",
        res_log[r0], model_value(8'b11_0_1_1_001));
    chk(res_log[r0+2] == model_value(8'b11_0_1_0_110), "R7 last value",
        res_log[r0+2], model_value(8'b11_0_1_0_110));
    finish_run();
  end
endmodule